// File: doc/BRIEF.md
# Ping-Pong Gamma Correction Table

This block applies a per-channel transfer curve to red, green and blue pixel components. Each channel has its own table, and the block holds two banks of that table set. The pixel path reads one bank while a host loads the other. The host loads a bank through a small register port. It writes a control word that picks the target bank, a colour write mask, the lookup mode and the bank to show. It then sets a starting index and streams data words. The index advances by one after every data word.

Each input component is split into two parts. The upper bits pick a segment and the lower bits form a fraction. The output is interpolated linearly between the two base entries that bound the segment, then rounded and clamped to the pixel width. The mode and bank select written by the host do not take effect at once. They are copied into active registers on a frame-start pulse. Two status outputs report those active copies, so software can always pick the idle bank as its next load target.

Top module: `gamma_lut_pingpong`

## Requirements
- R1: In bypass (active mode 0), each output component equals the input component, and `out_valid` follows `pix_valid` exactly two clock cycles later.
- R2: In RAM mode (active mode 2), the segment is s = x[PIX_W-1:FRAC_W] and the fraction is f = x[FRAC_W-1:0]. The output is lo + (((hi-lo)*f + 2^(FRAC_W-1)) >>> FRAC_W), where lo is entry s and hi is entry s+1 of the active bank for that channel.
- R3: Every interpolated result is clamped to the range 0 to 2^PIX_W-1.
- R4: Active mode values 1 and 3 behave like bypass.
- R5: The control register sits at address 0. Mode is in bits [1:0], shown-bank select in bit 4, host bank select in bit 8 and colour mask in bits [14:12]. After reset, mode is 0, both selects are 0 and the mask is 7.
- R6: A write to address 1 sets the write index. A write to address 2 stores bits [ENTRY_W-1:0] at the current index and then advances the index by one, so consecutive data writes fill consecutive entries.
- R7: Mask bit 2 enables the red table, bit 1 the green table and bit 0 the blue table. A mask of 7 writes all three tables at once.
- R8: Each table holds 2^SEG_BITS+1 entries. The last entry is the upper bound of the top segment and is used for the maximum input value.
- R9: The host select bit alone picks which bank receives data writes. Loading the bank that is not shown never changes the pixel output.
- R10: Mode and shown-bank select take effect only on the clock edge where `frame_start` is high. `status_mode` and `status_sel` report the active copies and hold steady between pulses.
- R11: A data write to the bank that is currently shown is accepted, and later pixels see the new entry.
- R12: After reset, `status_mode` is 0, `status_sel` is 0, `out_valid` is 0 and all output components are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register address: 0 control, 1 index, 2 data |
| host_wdata | input | HOST_W | Host write data |
| frame_start | input | 1 | One-cycle pulse that loads the active mode and bank |
| pix_valid | input | 1 | Input pixel valid |
| pix_r | input | PIX_W | Red input component |
| pix_g | input | PIX_W | Green input component |
| pix_b | input | PIX_W | Blue input component |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | PIX_W | Red output component |
| out_g | output | PIX_W | Green output component |
| out_b | output | PIX_W | Blue output component |
| status_mode | output | 2 | Active mode |
| status_sel | output | 1 | Active shown bank (0 = A, 1 = B) |

## Verification
A pixel presented before one rising edge produces its result on the second rising edge after it. The table read is registered at the first edge, and the interpolated value is registered at the second. The bench therefore drives each pixel on a falling edge and samples the outputs two falling edges later. Host writes land in the table at the next rising edge, and a frame-start pulse changes the status outputs at that same edge. Every lookup check therefore follows its setup writes by at least one full cycle. The bench also samples mode and bank behaviour both before and after the pulse, which shows that a pending select has no effect on the output until the frame boundary.

// File: rtl/gl_pkg.sv
package gl_pkg;
  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_INDEX = 2'd1;
  localparam logic [1:0] REG_DATA  = 2'd2;

  localparam logic [1:0] MODE_BYPASS = 2'd0;
  localparam logic [1:0] MODE_RAM    = 2'd2;

  localparam int CTRL_MODE_LSB = 0;
  localparam int CTRL_SEL_BIT  = 4;
  localparam int CTRL_HOST_BIT = 8;
  localparam int CTRL_MASK_LSB = 12;

  typedef struct packed {
    logic [1:0] mode;
    logic       sel;
    logic       host_sel;
    logic [2:0] mask;
  } ctrl_t;
endpackage

// File: rtl/gl_host_regs.sv
module gl_host_regs
  import gl_pkg::*;
#(
  parameter int HOST_W      = 32,
  parameter int IDX_W       = 5,
  parameter int ENTRY_W     = 12,
  parameter int NUM_ENTRIES = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic [1:0]         host_addr,
  input  logic [HOST_W-1:0]  host_wdata,
  output ctrl_t              ctrl,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [2:0]         wr_ch,
  output logic [ENTRY_W-1:0] wr_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic data_wr;
  assign data_wr = host_we && (host_addr == REG_DATA);
  assign wr_ch   = (data_wr && (wr_idx <= LAST_IDX)) ? ctrl.mask : 3'b000;
  assign wr_data = host_wdata[ENTRY_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl.mode     <= MODE_BYPASS;
      ctrl.sel      <= 1'b0;
      ctrl.host_sel <= 1'b0;
      ctrl.mask     <= 3'b111;
      wr_idx        <= '0;
    end else if (host_we) begin
      case (host_addr)
        REG_CTRL: begin
          ctrl.mode     <= host_wdata[CTRL_MODE_LSB +: 2];
          ctrl.sel      <= host_wdata[CTRL_SEL_BIT];
          ctrl.host_sel <= host_wdata[CTRL_HOST_BIT];
          ctrl.mask     <= host_wdata[CTRL_MASK_LSB +: 3];
        end
        REG_INDEX: wr_idx <= host_wdata[IDX_W-1:0];
        REG_DATA:  wr_idx <= wr_idx + 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gl_chan_lut.sv
module gl_chan_lut #(
  parameter int ENTRY_W  = 12,
  parameter int SEG_BITS = 4,
  parameter int IDX_W    = SEG_BITS + 1
) (
  input  logic                clk,
  input  logic                we,
  input  logic                wbank,
  input  logic [IDX_W-1:0]    widx,
  input  logic [ENTRY_W-1:0]  wdata,
  input  logic                rbank,
  input  logic [SEG_BITS-1:0] rseg,
  output logic [ENTRY_W-1:0]  lo,
  output logic [ENTRY_W-1:0]  hi
);
  localparam int EVEN_D = (1 << (SEG_BITS - 1)) + 1;
  localparam int ODD_D  = 1 << (SEG_BITS - 1);

  logic [SEG_BITS-1:0] w_half;
  logic [SEG_BITS:0]   seg_p1;
  logic [SEG_BITS-1:0] r_even;
  logic [SEG_BITS-2:0] r_odd;
  assign w_half = widx[IDX_W-1:1];
  assign seg_p1 = {1'b0, rseg} + 1'b1;
  assign r_even = seg_p1[SEG_BITS:1];
  assign r_odd  = rseg[SEG_BITS-1:1];

  logic [ENTRY_W-1:0] even_q [2];
  logic [ENTRY_W-1:0] odd_q  [2];
  logic               rbank_q, par_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [ENTRY_W-1:0] even_mem [EVEN_D];
    logic [ENTRY_W-1:0] odd_mem  [ODD_D];
    always_ff @(posedge clk) begin
      if (we && (wbank == 1'(b)) && !widx[0]) even_mem[w_half] <= wdata;
      if (we && (wbank == 1'(b)) &&  widx[0]) odd_mem[w_half[SEG_BITS-2:0]] <= wdata;
      even_q[b] <= even_mem[r_even];
      odd_q[b]  <= odd_mem[r_odd];
    end
  end

  always_ff @(posedge clk) begin
    rbank_q <= rbank;
    par_q   <= rseg[0];
  end

  logic [ENTRY_W-1:0] even_sel, odd_sel;
  assign even_sel = even_q[rbank_q];
  assign odd_sel  = odd_q[rbank_q];
  assign lo = par_q ? odd_sel  : even_sel;
  assign hi = par_q ? even_sel : odd_sel;
endmodule

// File: rtl/gl_interp.sv
module gl_interp #(
  parameter int ENTRY_W = 12,
  parameter int FRAC_W  = 6,
  parameter int PIX_W   = 10
) (
  input  logic [ENTRY_W-1:0] lo,
  input  logic [ENTRY_W-1:0] hi,
  input  logic [FRAC_W-1:0]  frac,
  output logic [PIX_W-1:0]   y
);
  localparam int W = ENTRY_W + FRAC_W + 3;
  localparam logic signed [W-1:0] HALF = W'(1 << (FRAC_W - 1));
  localparam logic signed [W-1:0] MAXV = W'((1 << PIX_W) - 1);

  logic signed [W-1:0] lo_s, hi_s, fr_s, prod, val;
  assign lo_s = W'(lo);
  assign hi_s = W'(hi);
  assign fr_s = W'(frac);
  assign prod = (hi_s - lo_s) * fr_s + HALF;
  assign val  = lo_s + (prod >>> FRAC_W);

  logic [W-1:0] val_unused;
  assign val_unused = val;

  always_comb begin
    if (val < 0)          y = '0;
    else if (val > MAXV)  y = MAXV[PIX_W-1:0];
    else                  y = val_unused[PIX_W-1:0];
  end
endmodule

// File: rtl/gamma_lut_pingpong.sv
module gamma_lut_pingpong
  import gl_pkg::*;
#(
  parameter int PIX_W    = 10,
  parameter int SEG_BITS = 4,
  parameter int ENTRY_W  = 12,
  parameter int HOST_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [1:0]        host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              frame_start,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_r,
  input  logic [PIX_W-1:0]  pix_g,
  input  logic [PIX_W-1:0]  pix_b,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b,
  output logic [1:0]        status_mode,
  output logic              status_sel
);
  localparam int FRAC_W      = PIX_W - SEG_BITS;
  localparam int NUM_ENTRIES = (1 << SEG_BITS) + 1;
  localparam int IDX_W       = SEG_BITS + 1;
  localparam int NCH         = 3;

  ctrl_t              ctrl;
  logic [IDX_W-1:0]   wr_idx;
  logic [2:0]         wr_ch;
  logic [ENTRY_W-1:0] wr_data;
  logic [1:0]         ctl_mode;
  logic               ctl_sel, ctl_hsel;

  gl_host_regs #(
    .HOST_W(HOST_W), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W), .NUM_ENTRIES(NUM_ENTRIES)
  ) u_regs (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .ctrl(ctrl), .wr_idx(wr_idx), .wr_ch(wr_ch),
    .wr_data(wr_data)
  );

  assign ctl_mode = ctrl.mode;
  assign ctl_sel  = ctrl.sel;
  assign ctl_hsel = ctrl.host_sel;

  // Active copies, loaded only at a frame boundary
  logic [1:0] act_mode;
  logic       act_sel;
  always_ff @(posedge clk) begin
    if (rst) begin
      act_mode <= MODE_BYPASS;
      act_sel  <= 1'b0;
    end else if (frame_start) begin
      act_mode <= ctl_mode;
      act_sel  <= ctl_sel;
    end
  end
  assign status_mode = act_mode;
  assign status_sel  = act_sel;

  logic [PIX_W-1:0]   pix_in  [NCH];
  logic [PIX_W-1:0]   s1_pix  [NCH];
  logic [FRAC_W-1:0]  s1_frac [NCH];
  logic [ENTRY_W-1:0] lo      [NCH];
  logic [ENTRY_W-1:0] hi      [NCH];
  logic [PIX_W-1:0]   interp  [NCH];
  logic [PIX_W-1:0]   res     [NCH];
  logic               s1_valid, s1_bypass;

  assign pix_in[0] = pix_r;
  assign pix_in[1] = pix_g;
  assign pix_in[2] = pix_b;

  // Stage 1: table read and operand capture
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_bypass <= 1'b1;
    end else begin
      s1_valid  <= pix_valid;
      s1_bypass <= (act_mode != MODE_RAM);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      s1_pix[c]  <= pix_in[c];
      s1_frac[c] <= pix_in[c][FRAC_W-1:0];
    end

    gl_chan_lut #(
      .ENTRY_W(ENTRY_W), .SEG_BITS(SEG_BITS), .IDX_W(IDX_W)
    ) u_lut (
      .clk(clk), .we(wr_ch[NCH-1-c]), .wbank(ctl_hsel), .widx(wr_idx),
      .wdata(wr_data), .rbank(act_sel), .rseg(pix_in[c][PIX_W-1:FRAC_W]),
      .lo(lo[c]), .hi(hi[c])
    );

    gl_interp #(
      .ENTRY_W(ENTRY_W), .FRAC_W(FRAC_W), .PIX_W(PIX_W)
    ) u_interp (
      .lo(lo[c]), .hi(hi[c]), .frac(s1_frac[c]), .y(interp[c])
    );

    // Stage 2: registered result
    always_ff @(posedge clk) begin
      if (rst) res[c] <= '0;
      else     res[c] <= s1_bypass ? s1_pix[c] : interp[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s1_valid;
  end

  assign out_r = res[0];
  assign out_g = res[1];
  assign out_b = res[2];
endmodule

// File: rtl/gl_checker.sv
module gl_checker #(
  parameter int PIX_W = 10,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             host_we,
  input logic [1:0]       host_addr,
  input logic             frame_start,
  input logic             pix_valid,
  input logic [PIX_W-1:0] pix_r,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_r,
  input logic [1:0]       status_mode,
  input logic             status_sel,
  input logic [1:0]       ctl_mode,
  input logic             ctl_sel,
  input logic [IDX_W-1:0] wr_idx
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst) pix_valid |-> ##2 out_valid); // R1
  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst) (pix_valid && status_mode != 2'd2) |-> ##2 (out_r == $past(pix_r, 2))); // R1
  AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (rst) frame_start |=> (status_sel == $past(ctl_sel) && status_mode == $past(ctl_mode))); // R10
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst) !frame_start |=> ($stable(status_sel) && $stable(status_mode))); // R10
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst) (host_we && host_addr == 2'd2) |=> (wr_idx == IDX_W'($past(wr_idx) + 1'b1))); // R6
endmodule

bind gamma_lut_pingpong gl_checker #(.PIX_W(PIX_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
  .frame_start(frame_start), .pix_valid(pix_valid), .pix_r(pix_r),
  .out_valid(out_valid), .out_r(out_r), .status_mode(status_mode),
  .status_sel(status_sel), .ctl_mode(ctl_mode), .ctl_sel(ctl_sel),
  .wr_idx(wr_idx)
);

// File: tb/sim_gamma_lut_pingpong.sv
`timescale 1ns/1ps
module sim_gamma_lut_pingpong;
  localparam int PIX_W = 10, SEG_BITS = 4, ENTRY_W = 12, HOST_W = 32;
  localparam int FRAC_W = PIX_W - SEG_BITS;
  localparam int NENT = (1 << SEG_BITS) + 1;
  localparam int MAXV = (1 << PIX_W) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic host_we = 1'b0;
  logic [1:0] host_addr = '0;
  logic [HOST_W-1:0] host_wdata = '0;
  logic frame_start = 1'b0, pix_valid = 1'b0;
  logic [PIX_W-1:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic out_valid;
  logic [PIX_W-1:0] out_r, out_g, out_b;
  logic [1:0] status_mode;
  logic status_sel;

  always #10 clk = ~clk;

  gamma_lut_pingpong #(.PIX_W(PIX_W), .SEG_BITS(SEG_BITS), .ENTRY_W(ENTRY_W), .HOST_W(HOST_W)) u0 (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .frame_start(frame_start), .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .status_mode(status_mode), .status_sel(status_sel)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int tbl [2][3][NENT];
  int cur_mode = 0, cur_sel = 0, cur_hsel = 0, cur_mask = 7, wr_ptr = 0;
  int exp_mode = 0, exp_sel = 0;

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int cw(int mode, int sel, int hsel, int mask);
    return mode | (sel << 4) | (hsel << 8) | (mask << 12);
  endfunction

  function automatic int curve(int kind, int k);
    case (kind)
      0: return k * 64;
      1: return 1023 - k * 60;
      2: return k * k * 4;
      default: return 1500 + k * 10;
    endcase
  endfunction

  function automatic int model(int c, int x);
    int s, f, lo, hi, v;
    if (exp_mode != 2) return x;
    s = x >> FRAC_W;
    f = x & ((1 << FRAC_W) - 1);
    lo = tbl[exp_sel][c][s];
    hi = tbl[exp_sel][c][s + 1];
    v = lo + (((hi - lo) * f + (1 << (FRAC_W - 1))) >>> FRAC_W);
    if (v < 0) v = 0;
    if (v > MAXV) v = MAXV;
    return v;
  endfunction

  task automatic host_wr(int addr, int data);
    @(negedge clk);
    host_we = 1'b1; host_addr = 2'(addr); host_wdata = HOST_W'(data);
    @(negedge clk);
    host_we = 1'b0;
    if (addr == 0) begin
      cur_mode = data & 3; cur_sel = (data >> 4) & 1;
      cur_hsel = (data >> 8) & 1; cur_mask = (data >> 12) & 7;
    end else if (addr == 1) begin
      wr_ptr = data & 31;
    end else if (addr == 2) begin
      if (wr_ptr < NENT)
        for (int c = 0; c < 3; c++)
          if (cur_mask[2 - c]) tbl[cur_hsel][c][wr_ptr] = data & ((1 << ENTRY_W) - 1);
      wr_ptr = (wr_ptr + 1) & 31;
    end
  endtask

  task automatic load_curve(int kind);
    host_wr(1, 0);
    for (int k = 0; k < NENT; k++) host_wr(2, curve(kind, k));
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    exp_mode = cur_mode; exp_sel = cur_sel;
  endtask

  task automatic send_pix(string req, int r, int g, int b);
    @(negedge clk);
    pix_valid = 1'b1; pix_r = PIX_W'(r); pix_g = PIX_W'(g); pix_b = PIX_W'(b);
    @(negedge clk);
    pix_valid = 1'b0;
    @(negedge clk);
    check(req, int'(out_valid), 1);
    check(req, int'(out_r), model(0, r));
    check(req, int'(out_g), model(1, g));
    check(req, int'(out_b), model(2, b));
  endtask

  task automatic t_reset();
    check("R12", int'(status_mode), 0);
    check("R12", int'(status_sel), 0);
    check("R12", int'(out_valid), 0);
    check("R12", int'(out_r), 0);
  endtask

  task automatic t_bypass();
    send_pix("R1", 0, 511, 1023);
    send_pix("R1", 37, 900, 2);
  endtask

  task automatic t_load_a();
    // R5: reset mask 7 and host bank A apply before any control write
    load_curve(0);
    host_wr(0, cw(2, 0, 0, 7));
    send_pix("R10", 100, 200, 300);   // still bypass before frame boundary
    check("R10", int'(status_mode), 0);
    frame();
    check("R10", int'(status_mode), 2);
    send_pix("R2", 0, 64, 100);
    send_pix("R2", 517, 3, 700);
    send_pix("R8", 1023, 1023, 1000);
  endtask

  task automatic t_mask_b();
    host_wr(0, cw(2, 0, 1, 4)); load_curve(1);   // R7 red only
    host_wr(0, cw(2, 0, 1, 2)); load_curve(2);   // R7 green only
    host_wr(0, cw(2, 0, 1, 1)); load_curve(3);   // R7 blue only
    send_pix("R9", 300, 650, 1023);               // bank A still shown
    host_wr(0, cw(2, 1, 1, 7));
    send_pix("R10", 300, 650, 1023);              // select pending
    check("R10", int'(status_sel), 0);
    frame();
    check("R10", int'(status_sel), 1);
    send_pix("R7", 300, 650, 40);
    send_pix("R3", 1023, 1023, 999);              // blue table above range clamps
  endtask

  task automatic t_active_write();
    host_wr(0, cw(2, 1, 1, 2));
    host_wr(1, 5);
    host_wr(2, 777);                              // R11 shown bank green entry 5
    send_pix("R11", 320, 320, 320);
    check("R11", int'(out_g), 777);
    host_wr(0, cw(2, 1, 1, 4));
    host_wr(1, 3);
    host_wr(2, 100);
    host_wr(2, 200);                              // R6 index advanced to 4
    send_pix("R6", 192, 0, 0);
    check("R6", int'(out_r), 100);
    send_pix("R6", 256, 0, 0);
    check("R6", int'(out_r), 200);
  endtask

  task automatic t_odd_modes();
    host_wr(0, cw(1, 1, 0, 7));
    frame();
    check("R4", int'(status_mode), 1);
    send_pix("R4", 12, 345, 678);
    host_wr(0, cw(3, 0, 0, 7));
    frame();
    send_pix("R4", 1023, 0, 513);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_load_a();
    t_mask_b();
    t_active_write();
    t_odd_modes();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule